// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Controller

This block keeps the eight-bit status byte of a serial flash device and decides whether each write-type request may proceed. A command decoder ahead of it delivers single-cycle strobes: set write enable, clear write enable, status write with its data byte, and an erase or program request carrying its kind and byte address. The block answers each status write and each erase or program request with a one-cycle grant or deny pulse, and runs an internal cycle timer that models the self-timed busy period of a granted operation.

Protection comes from three block-select bits and a top/bottom bit, which together carve a protected region of one eighth, one quarter, one half or the whole of the array, or nothing at all. A status-lock bit, qualified by the level of the write-protect pin, can freeze the status byte. Nonvolatile bits are ordinary flops. A small serializer presents the live status byte one bit per shift tick, most significant bit first, wrapping around for as long as ticks continue. Shifting on the serial wire and the memory array itself live elsewhere.

Top module: `fsr_protect_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, busy is low, and neither grant nor deny is asserted.
- R2: The status byte is {lock, 0, top_bottom, sel[2:0], wen, busy}: bit 0 is busy (1 = operation in progress), bit 1 write enable, bits 4:2 block-select bits 2..0, bit 5 top/bottom, bit 6 always 0, bit 7 status lock.
- R3: A set-enable strobe makes bit 1 read 1 in the next cycle; a clear-enable strobe makes it read 0 in the next cycle.
- R4: Every request (req_valid_i) and every status write (cmd_wrsr_i) receives exactly one of grant_o or deny_o in the following cycle; it is denied when busy is 1 or write enable is 0 in the request cycle.
- R5: A granted status write replaces only bits 7 and 5:2, taking them from data bits 7 and 5:2, and the new values appear in the cycle busy falls; data bits 6, 1 and 0 have no effect.
- R6: A status write is denied when the lock bit is 1 and wp_pin_i is 0; with wp_pin_i at 1 the lock has no effect.
- R7: With sel[2]=0 and sel[1:0] of 01, 10 or 11, the protected region is the top 1/8, 1/4 or 1/2 of the array (addresses with the highest address bits all 1) when top_bottom is 0, and the bottom region (those bits all 0) when top_bottom is 1; sel[2]=1 protects everything and sel=000 nothing. A sector erase, small sector erase or page program (req_kind_i 1, 0, 3) aimed at a protected address is denied.
- R8: A chip erase (req_kind_i 2) is granted only when sel is 000, whatever top_bottom and the address hold.
- R9: A denied request or status write leaves write enable unchanged.
- R10: A grant raises busy in the same cycle as the grant pulse; busy stays high for exactly SSE_CYC, SE_CYC, CE_CYC, PP_CYC or SRW_CYC cycles (small sector erase, sector erase, chip erase, page program, status write), and write enable reads 0 in the cycle busy falls.
- R11: A set-enable strobe sampled in the last busy cycle takes precedence over the completion clear, so write enable reads 1 once busy falls.
- R12: A read-start pulse points rd_bit_o at status bit 7 in the next cycle; each shift tick moves it one bit lower, and the tick after bit 0 returns it to bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_pin_i | input | 1 | Write-protect pin level (0 = protect asserted) |
| cmd_wren_i | input | 1 | Set write-enable strobe |
| cmd_wrdi_i | input | 1 | Clear write-enable strobe |
| cmd_wrsr_i | input | 1 | Status write strobe |
| wrsr_data_i | input | 8 | Data byte of the status write |
| req_valid_i | input | 1 | Erase or program request strobe |
| req_kind_i | input | 2 | 0 small sector erase, 1 sector erase, 2 chip erase, 3 page program |
| req_addr_i | input | ADDR_W | Byte address of the request |
| rd_start_i | input | 1 | Restart status serialization at bit 7 |
| rd_tick_i | input | 1 | Advance the serialized status bit |
| status_o | output | 8 | Live status byte |
| grant_o | output | 1 | Request or status write accepted |
| deny_o | output | 1 | Request or status write rejected |
| busy_o | output | 1 | Internal operation in progress |
| rd_bit_o | output | 1 | Currently selected status bit |

## Verification
The completion of a timed operation and a set-enable strobe can land in the same cycle, and both want to drive write enable. The bench counts the busy cycles of a page program, places the strobe on the final busy cycle, and expects write enable to read 1 once busy has fallen, compared against a plain completion that leaves it at 0. A second overlap, a request arriving while the timer is still counting, is provoked by issuing it the cycle after a grant and must come back as a deny that leaves the running operation's length intact.

// File: rtl/fsr_pkg.sv
// Package: shared kinds, status bit positions and helpers for the
// status register protect controller. Assumes an 8-bit status byte.
package fsr_pkg;

    typedef enum logic [1:0] {
        KIND_SSE = 2'd0,   // small sector erase
        KIND_SE  = 2'd1,   // sector erase
        KIND_CE  = 2'd2,   // whole-array erase
        KIND_PP  = 2'd3    // page program
    } wr_kind_e;

    localparam int STAT_W    = 8;
    localparam int BIT_BUSY  = 0;
    localparam int BIT_WEN   = 1;
    localparam int BIT_SEL_L = 2;
    localparam int BIT_SEL_H = 4;
    localparam int BIT_TB    = 5;
    localparam int BIT_LOCK  = 7;
    localparam int SEL_W     = 3;
    localparam int REGION_W  = 3;   // address MSBs that define a region

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsr_region_decode.sv
// Module: fsr_region_decode
// Decides whether an address falls in the protected region chosen by the
// select bits and the top/bottom bit. Only the REGION_W most significant
// address bits matter, since every region is a power-of-two fraction of
// the array aligned to one end. Purely combinational.
module fsr_region_decode
    import fsr_pkg::*;
(
    input  logic                top_bottom_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [REGION_W-1:0] addr_msb_i,
    output logic                prot_o,
    output logic                any_prot_o
);

    logic [REGION_W-1:0] cmp_mask;
    logic [REGION_W-1:0] edge_pat;
    logic                frac_hit;

    // Build the mask of address MSBs that must match the region end.
    for (genvar i = 0; i < REGION_W; i++) begin : g_mask
        // bit i participates when the region is small enough to need it
        assign cmp_mask[i] = (sel_i[1:0] != 2'b00) &&
                             (int'(i) >= int'(sel_i[1:0]) - 1);
    end

    // Top region sits at all-ones MSBs, bottom region at all-zeros.
    assign edge_pat = {REGION_W{~top_bottom_i}};

    // A fractional region hits when all masked MSBs equal the edge pattern.
    assign frac_hit = (sel_i[1:0] != 2'b00) &&
                      (((addr_msb_i ^ edge_pat) & cmp_mask) == '0);

    assign prot_o     = sel_i[2] | frac_hit;
    assign any_prot_o = (sel_i != '0);

endmodule

// File: rtl/fsr_busy_timer.sv
// Module: fsr_busy_timer
// Down-counter modelling a self-timed internal operation. A load sets the
// remaining cycle count; busy is high while the count is nonzero and done
// marks the final busy cycle. Assumes load values of at least 1 and that
// loads arrive only while idle.
module fsr_busy_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             busy_o,
    output logic             done_o
);

    logic [CNT_W-1:0] remain_q;

    // Count remaining busy cycles down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= load_val_i;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy_o = (remain_q != '0);
    assign done_o = (remain_q == CNT_W'(1));

endmodule

// File: rtl/fsr_status_serial.sv
// Module: fsr_status_serial
// Points at one bit of the live status byte for serial read-out. Start
// selects the top bit; each tick moves one bit lower and wraps from bit 0
// to the top bit. Start wins over a tick in the same cycle.
module fsr_status_serial
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic [STAT_W-1:0] status_i,
    output logic              bit_o
);

    localparam int IDX_W = $clog2(STAT_W);

    logic [IDX_W-1:0] idx_q;

    // Track which status bit is presented next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= IDX_W'(STAT_W - 1);
        end else if (start_i) begin
            idx_q <= IDX_W'(STAT_W - 1);
        end else if (tick_i) begin
            idx_q <= idx_q - 1'b1;
        end
    end

    assign bit_o = status_i[idx_q];

endmodule

// File: rtl/fsr_protect_ctrl.sv
// Module: fsr_protect_ctrl (top)
// Holds the flash status byte, grants or denies erase, program and status
// write requests against write enable, busy, the protected region and the
// status lock, and times each granted operation. Assumes the command
// strobes are mutually exclusive in any one cycle. Nonvolatile bits are
// plain flops cleared by reset.
module fsr_protect_ctrl
    import fsr_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int SSE_CYC = 8,
    parameter int SE_CYC  = 12,
    parameter int CE_CYC  = 20,
    parameter int PP_CYC  = 6,
    parameter int SRW_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin_i,
    input  logic              cmd_wren_i,
    input  logic              cmd_wrdi_i,
    input  logic              cmd_wrsr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              req_valid_i,
    input  logic [1:0]        req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              rd_start_i,
    input  logic              rd_tick_i,
    output logic [7:0]        status_o,
    output logic              grant_o,
    output logic              deny_o,
    output logic              busy_o,
    output logic              rd_bit_o
);

    localparam int MAX_CYC = imax(imax(imax(SSE_CYC, SE_CYC), imax(CE_CYC, PP_CYC)), SRW_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    wr_kind_e         kind;
    logic             wen_q;
    logic [SEL_W-1:0] sel_q;
    logic             tb_q;
    logic             lock_q;
    logic             pend_q;
    logic [SEL_W-1:0] pend_sel_q;
    logic             pend_tb_q;
    logic             pend_lock_q;
    logic             grant_q;
    logic             deny_q;
    logic             busy;
    logic             done;
    logic             addr_prot;
    logic             any_prot;
    logic             may_write;
    logic             req_ok;
    logic             wrsr_ok;
    logic             start_op;
    logic [CNT_W-1:0] load_val;
    logic             ignored_unused;

    assign kind = wr_kind_e'(req_kind_i);

    fsr_region_decode u_region (
        .top_bottom_i (tb_q),
        .sel_i        (sel_q),
        .addr_msb_i   (req_addr_i[ADDR_W-1 -: REGION_W]),
        .prot_o       (addr_prot),
        .any_prot_o   (any_prot)
    );

    // Decide acceptance of requests and status writes in the request cycle.
    always_comb begin
        may_write = wen_q && !busy;
        if (kind == KIND_CE) begin
            req_ok = req_valid_i && may_write && !any_prot;
        end else begin
            req_ok = req_valid_i && may_write && !addr_prot;
        end
        wrsr_ok  = cmd_wrsr_i && may_write && !(lock_q && !wp_pin_i);
        start_op = req_ok || wrsr_ok;
    end

    // Pick the busy length for the operation being started.
    always_comb begin
        if (wrsr_ok) begin
            load_val = CNT_W'(SRW_CYC);
        end else begin
            unique case (kind)
                KIND_SSE: load_val = CNT_W'(SSE_CYC);
                KIND_SE:  load_val = CNT_W'(SE_CYC);
                KIND_CE:  load_val = CNT_W'(CE_CYC);
                default:  load_val = CNT_W'(PP_CYC);
            endcase
        end
    end

    fsr_busy_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_op),
        .load_val_i (load_val),
        .busy_o     (busy),
        .done_o     (done)
    );

    // Write-enable latch: set strobe beats the completion clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q <= 1'b0;
        end else if (cmd_wren_i) begin
            wen_q <= 1'b1;
        end else if (cmd_wrdi_i || done) begin
            wen_q <= 1'b0;
        end
    end

    // Hold accepted status write data until its timed cycle completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_sel_q  <= '0;
            pend_tb_q   <= 1'b0;
            pend_lock_q <= 1'b0;
        end else if (wrsr_ok) begin
            pend_q      <= 1'b1;
            pend_sel_q  <= wrsr_data_i[BIT_SEL_H:BIT_SEL_L];
            pend_tb_q   <= wrsr_data_i[BIT_TB];
            pend_lock_q <= wrsr_data_i[BIT_LOCK];
        end else if (done) begin
            pend_q      <= 1'b0;
        end
    end

    // Commit the writable status bits at completion of a status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            tb_q   <= 1'b0;
            lock_q <= 1'b0;
        end else if (done && pend_q) begin
            sel_q  <= pend_sel_q;
            tb_q   <= pend_tb_q;
            lock_q <= pend_lock_q;
        end
    end

    // Register the one-cycle answer to each request or status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
        end else begin
            grant_q <= start_op;
            deny_q  <= (req_valid_i || cmd_wrsr_i) && !start_op;
        end
    end

    assign status_o = {lock_q, 1'b0, tb_q, sel_q, wen_q, busy};
    assign grant_o  = grant_q;
    assign deny_o   = deny_q;
    assign busy_o   = busy;

    fsr_status_serial u_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (rd_start_i),
        .tick_i   (rd_tick_i),
        .status_i (status_o),
        .bit_o    (rd_bit_o)
    );

    // Data bits that no status write may change, and address bits below
    // region granularity.
    assign ignored_unused = ^{wrsr_data_i[6], wrsr_data_i[1:0],
                              req_addr_i[ADDR_W-REGION_W-1:0]};

endmodule

// File: rtl/fsr_protect_chk.sv
// Module: fsr_protect_chk
// Property checker for fsr_protect_ctrl, attached by bind. Observes ports
// only and holds no state of its own.
module fsr_protect_chk
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_pin_i,
    input logic              cmd_wren_i,
    input logic              cmd_wrdi_i,
    input logic              cmd_wrsr_i,
    input logic [7:0]        wrsr_data_i,
    input logic              req_valid_i,
    input logic [1:0]        req_kind_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              rd_start_i,
    input logic              rd_tick_i,
    input logic [7:0]        status_o,
    input logic              grant_o,
    input logic              deny_o,
    input logic              busy_o,
    input logic              rd_bit_o
);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6] == 1'b0);

    p_busy_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[BIT_BUSY] == busy_o);

    p_wen_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wren_i |=> status_o[BIT_WEN]);

    p_answer_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && deny_o));

    p_answer_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i || cmd_wrsr_i) |=> (grant_o || deny_o));

    p_busy_denies_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_valid_i || cmd_wrsr_i) && busy_o) |=> deny_o);

    p_no_wen_denies_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_valid_i || cmd_wrsr_i) && !status_o[BIT_WEN]) |=> deny_o);

    p_lock_denies_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr_i && status_o[BIT_LOCK] && !wp_pin_i) |=> deny_o);

    p_chip_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_kind_i == KIND_CE &&
         status_o[BIT_SEL_H:BIT_SEL_L] != 3'b000) |=> deny_o);

    p_grant_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> busy_o);

    p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !$past(cmd_wren_i)) |-> !status_o[BIT_WEN]);

    p_late_wren_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && $past(cmd_wren_i)) |-> status_o[BIT_WEN]);

    p_start_top_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start_i |=> (rd_bit_o == status_o[BIT_LOCK]));

endmodule

bind fsr_protect_ctrl fsr_protect_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_fsr_protect_ctrl.sv
// Scoreboard bench for fsr_protect_ctrl: driver tasks queue the expected
// grant/deny answer, a monitor pops and compares each answer it sees.
module tb_fsr_protect_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 19;
    localparam int ARRAY      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_pin = 1'b1;
    logic          wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0;
    logic [7:0]    wrsr_data = 8'h00;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic          rd_start = 1'b0, rd_tick = 1'b0;
    logic [7:0]    status;
    logic          grant, deny, busy, rd_bit;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;
    bit  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fsr_protect_ctrl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .wp_pin_i(wp_pin),
        .cmd_wren_i(wren), .cmd_wrdi_i(wrdi), .cmd_wrsr_i(wrsr),
        .wrsr_data_i(wrsr_data), .req_valid_i(req_valid),
        .req_kind_i(req_kind), .req_addr_i(req_addr),
        .rd_start_i(rd_start), .rd_tick_i(rd_tick),
        .status_o(status), .grant_o(grant), .deny_o(deny),
        .busy_o(busy), .rd_bit_o(rd_bit)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Monitor: every answer pulse must match the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && (grant || deny)) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R4 unexpected answer: got grant=%0b deny=%0b expected none", grant, deny);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, {grant, deny}, {e, ~e});
            end
        end
    end

    function automatic bit prot_model(input bit tb, input logic [2:0] sel, input int addr);
        int frac;
        if (sel[2]) return 1'b1;
        if (sel[1:0] == 2'b00) return 1'b0;
        frac = ARRAY >> (4 - int'(sel[1:0]));
        if (!tb) return addr >= ARRAY - frac;
        return addr < frac;
    endfunction

    task automatic strobe_wren();
        @(negedge clk) wren = 1'b1;
        @(negedge clk) wren = 1'b0;
    endtask

    task automatic strobe_wrdi();
        @(negedge clk) wrdi = 1'b1;
        @(negedge clk) wrdi = 1'b0;
    endtask

    task automatic issue_req(input logic [1:0] k, input int a, input bit e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk) begin req_valid = 1'b1; req_kind = k; req_addr = AW'(a); end
        @(negedge clk) req_valid = 1'b0;
    endtask

    task automatic issue_wrsr(input logic [7:0] d, input bit e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk) begin wrsr = 1'b1; wrsr_data = d; end
        @(negedge clk) wrsr = 1'b0;
    endtask

    // Count negedges with busy high, starting at the current negedge.
    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int n;
        int addrs[12] = '{32'h00000, 32'h0FFFF, 32'h10000, 32'h1FFFF,
                          32'h20000, 32'h3FFFF, 32'h40000, 32'h5FFFF,
                          32'h60000, 32'h6FFFF, 32'h70000, 32'h7FFFF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", status, 8'h00);
        check("R1 busy", busy, 0);
        check("R1 answers", {grant, deny}, 2'b00);

        // R3 set and clear write enable
        strobe_wren();
        check("R3 wen set", status, 8'h02);
        strobe_wrdi();
        check("R3 wen clear", status, 8'h00);

        // R4 request without write enable is denied; R9 wen stays 0
        issue_req(2'd0, 0, 1'b0, "R4 no-wen deny");
        check("R9 wen after deny", status[1], 0);

        // R5 status write of FFh: only bits 7,5:2 change, at completion
        strobe_wren();
        issue_wrsr(8'hFF, 1'b1, "R5 wrsr grant");
        check("R5 during busy old bits", status, 8'h03);
        wait_idle(n);
        check("R10 status write length", n, 10);
        check("R5 committed byte", status, 8'hBC);

        // R6 lock with wp low blocks status write; R9 wen retained
        wp_pin = 1'b0;
        strobe_wren();
        issue_wrsr(8'h00, 1'b0, "R6 locked deny");
        check("R9 wen kept after lock deny", status, 8'hBE);
        wp_pin = 1'b1;
        issue_wrsr(8'h00, 1'b1, "R6 wp high grant");
        wait_idle(n);
        check("R6 unlocked write result", status, 8'h00);

        // R12 serial read-out of A6h: bits 7..0 then wrap to 7
        strobe_wren();
        issue_wrsr(8'hA4, 1'b1, "R12 setup grant");
        wait_idle(n);
        strobe_wren();
        check("R12 setup byte", status, 8'hA6);
        @(negedge clk) rd_start = 1'b1;
        @(negedge clk) rd_start = 1'b0;
        check("R12 first bit", rd_bit, 1'b1);
        rd_tick = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check($sformatf("R12 tick %0d", k), rd_bit, 8'hA6 >> ((7 - k) & 7) & 1);
        end
        rd_tick = 1'b0;
        // restore an unprotected status
        issue_wrsr(8'h00, 1'b1, "R6 clear grant");
        wait_idle(n);
        check("R2 cleared byte", status, 8'h00);

        // R4 request while busy is denied
        strobe_wren();
        issue_req(2'd3, 32'h100, 1'b1, "R4 first grant");
        issue_req(2'd0, 0, 1'b0, "R4 busy deny");
        wait_idle(n);

        // R10 busy length per kind, wen clear at the end
        strobe_wren();
        issue_req(2'd3, 32'h200, 1'b1, "R10 pp grant");
        wait_idle(n);
        check("R10 pp length", n, 6);
        check("R10 wen cleared", status[1], 0);
        strobe_wren();
        issue_req(2'd0, 32'h3000, 1'b1, "R10 sse grant");
        wait_idle(n);
        check("R10 sse length", n, 8);
        strobe_wren();
        issue_req(2'd1, 32'h30000, 1'b1, "R10 se grant");
        wait_idle(n);
        check("R10 se length", n, 12);
        strobe_wren();
        issue_req(2'd2, 0, 1'b1, "R10 ce grant");
        wait_idle(n);
        check("R10 ce length", n, 20);

        // R11 set-enable on the final busy cycle survives completion
        strobe_wren();
        issue_req(2'd3, 32'h400, 1'b1, "R11 pp grant");
        repeat (5) @(negedge clk);
        wren = 1'b1;
        @(negedge clk) wren = 1'b0;
        check("R11 busy fallen", busy, 0);
        check("R11 wen kept", status[1], 1);
        strobe_wrdi();

        // R7 and R8 sweep of every top/bottom and select combination
        for (int c = 0; c < 16; c++) begin
            automatic bit         tb  = c[3];
            automatic logic [2:0] sel = c[2:0];
            strobe_wren();
            issue_wrsr({2'b01, tb, sel, 2'b11}, 1'b1, "R5 sweep setup");
            wait_idle(n);
            check($sformatf("R5 sweep byte c%0d", c), status, {2'b00, tb, sel, 2'b00});
            for (int i = 0; i < 12; i++) begin
                automatic bit ok = !prot_model(tb, sel, addrs[i]);
                strobe_wren();
                issue_req(2'd0, addrs[i], ok,
                          $sformatf("R7 tb=%0b sel=%0d addr=%05h", tb, sel, addrs[i]));
                if (ok) begin
                    wait_idle(n);
                end else begin
                    check("R9 wen after protect deny", status[1], 1);
                    strobe_wrdi();
                end
            end
            strobe_wren();
            issue_req(2'd2, 32'h7FFFF, sel == 3'b000,
                      $sformatf("R8 chip tb=%0b sel=%0d", tb, sel));
            if (sel == 3'b000) wait_idle(n);
            else strobe_wrdi();
        end

        repeat (2) @(negedge clk);
        check("R4 all answers seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule